// File: doc/BRIEF.md
# DMA Channel Teardown Controller

This block is the control engine of one channel of a descriptor-based DMA. Software programs the channel through a single 32-bit configuration register: an enable bit, a teardown request bit, and, for receive channels only, a starvation-retry bit, a host-descriptor-type bit and a completion queue number. While the channel is enabled and not being torn down, it accepts one transfer descriptor at a time from the fetch side and tracks it as in flight.

When software writes the register with both the enable and the teardown bits set, the channel stops in an orderly way. A transmit channel that holds a transfer first hands that descriptor back to its completion queue. A receive channel drops its pending transfer immediately and does not return it. The block then writes a teardown marker word into descriptor memory and pushes the marker's address to a dedicated teardown completion queue. Host software polls that queue, and the teardown is finished once the marker has been accepted. A later write of zero turns the channel fully off. The direction, port number, queue numbers and marker address are fixed by parameters for each instance.

Top module: `dma_chan_teardown`

## Requirements
- R1: After reset, the configuration value is zero, no transfer is in flight, teardown_busy is low, and neither qpush_valid nor dmem_we is asserted.
- R2: A configuration write keeps only the fields that apply to the channel direction. Transmit keeps bits 31 (enable) and 30 (teardown). Receive also keeps bit 24 (starvation retry), bit 14 (host descriptor type) and the completion queue number in bits CQW-1:0. All other bits read back as zero.
- R3: chan_accept is high exactly when enable is set and teardown is clear. A one-cycle xfer_load while chan_accept is high and nothing is in flight captures xfer_desc and raises xfer_busy. xfer_done clears it. Loads made while chan_accept is low have no effect.
- R4: In a transmit channel torn down while busy, the in-flight descriptor is pushed to queue TX_CQ_NUM before the marker word is written.
- R5: In a receive channel, teardown discards the in-flight descriptor at once, and the only descriptor pushed is the marker.
- R6: In a channel that is idle when teardown is requested, only the marker is pushed.
- R7: The marker word is written to address TD_DESC_ADDR, with value 0x13 in bits 31:27, bit 16 set for receive, and PORT_ID in bits 4:0. This write happens in the cycle before the marker push is offered.
- R8: The marker push carries queue TD_CQ_NUM and descriptor TD_DESC_ADDR. Every push holds its queue number and descriptor while qpush_ready is low.
- R9: teardown_busy rises in the cycle after the teardown write and falls in the cycle after the marker push is accepted. chan_accept stays low while it is high.
- R10: Any configuration write made while teardown_busy is high is ignored.
- R11: Writing zero after a teardown clears the configuration value and leaves chan_accept low.
- R12: With qpush_ready held high, teardown_busy lasts 3 cycles for a busy transmit channel and 2 cycles in every other case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration register write strobe |
| cfg_wr_data | input | 32 | Configuration write value |
| cfg_value | output | 32 | Stored configuration after direction masking |
| chan_accept | output | 1 | Channel takes new transfer descriptors |
| teardown_busy | output | 1 | Teardown in progress |
| xfer_load | input | 1 | Fetch side hands over a transfer descriptor |
| xfer_desc | input | AW | Address of that descriptor |
| xfer_done | input | 1 | In-flight transfer finished normally |
| xfer_busy | output | 1 | A transfer descriptor is in flight |
| qpush_valid | output | 1 | Push request to the queue manager |
| qpush_ready | input | 1 | Queue manager accepts the push |
| qpush_qnum | output | QW | Target queue number |
| qpush_desc | output | AW | Descriptor address pushed |
| dmem_we | output | 1 | Descriptor memory write strobe |
| dmem_addr | output | AW | Descriptor memory write address |
| dmem_wdata | output | 32 | Marker word |

## Verification
Every output is a registered function of the state, so a write or load sampled at one edge shows up in the outputs from the next edge onward. The marker write follows the release handshake by one cycle, and the marker push follows the write by one cycle. A behavioural model in the bench advances at each rising edge from the same inputs and is compared with a transmit instance and a receive instance half a cycle later, every cycle. Directed checks time the busy window in cycles and count handshakes at the push port. They also probe the state while qpush_ready is held low, to catch the release and marker ordering and any write made during teardown.

// File: rtl/dct_pkg.sv
package dct_pkg;
   typedef enum logic [1:0] {
      TD_IDLE      = 2'd0,
      TD_RELEASE   = 2'd1,
      TD_MARK_WR   = 2'd2,
      TD_MARK_PUSH = 2'd3
   } td_state_e;

   localparam int CFG_EN_BIT    = 31;
   localparam int CFG_TD_BIT    = 30;
   localparam int CFG_RETRY_BIT = 24;
   localparam int CFG_HOST_BIT  = 14;

   localparam logic [4:0] MARKER_TYPE = 5'h13;

   // type in 31:27, receive flag in 16, port in 4:0
   function automatic logic [31:0] marker_word(input logic is_rx, input logic [4:0] port);
      marker_word = {MARKER_TYPE, 10'd0, is_rx, 11'd0, port};
   endfunction
endpackage

// File: rtl/dct_cfg_reg.sv
module dct_cfg_reg
   import dct_pkg::*;
#(
   parameter bit IS_RX = 1'b0,
   parameter int CQW   = 12
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en_i,
   input  logic [31:0] wr_data_i,
   input  logic        lock_i,
   output logic [31:0] cfg_o,
   output logic        td_start_o
);
   localparam logic [31:0] CQ_MASK = (32'd1 << CQW) - 32'd1;
   localparam logic [31:0] CTRL_MASK = (32'd1 << CFG_EN_BIT) | (32'd1 << CFG_TD_BIT);
   localparam logic [31:0] RX_MASK = CTRL_MASK | (32'd1 << CFG_RETRY_BIT)
                                     | (32'd1 << CFG_HOST_BIT) | CQ_MASK;

   logic [31:0] keep_mask;
   logic        wr_ok;

   generate
      if (IS_RX) begin : g_rx_fields
         assign keep_mask = RX_MASK;
      end else begin : g_tx_fields
         assign keep_mask = CTRL_MASK;
      end
   endgenerate

   assign wr_ok      = wr_en_i && !lock_i;
   assign td_start_o = wr_ok && wr_data_i[CFG_EN_BIT] && wr_data_i[CFG_TD_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_o <= '0;
      end else if (wr_ok) begin
         cfg_o <= wr_data_i & keep_mask;
      end
   end

   p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_i && wr_en_i) |=> $stable(cfg_o));
endmodule

// File: rtl/dct_inflight.sv
module dct_inflight #(
   parameter int AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [AW-1:0] addr_i,
   input  logic          done_i,
   input  logic          drop_i,
   output logic          busy_o,
   output logic [AW-1:0] desc_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_o <= 1'b0;
         desc_o <= '0;
      end else if (drop_i) begin
         busy_o <= 1'b0;
      end else if (load_i && !busy_o) begin
         busy_o <= 1'b1;
         desc_o <= addr_i;
      end else if (done_i) begin
         busy_o <= 1'b0;
      end
   end

   p_desc_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !drop_i) |=> $stable(desc_o));
endmodule

// File: rtl/dct_td_seq.sv
module dct_td_seq
   import dct_pkg::*;
#(
   parameter bit            IS_RX   = 1'b0,
   parameter int            AW      = 32,
   parameter int            QW      = 12,
   parameter logic [QW-1:0] TD_CQ   = '0,
   parameter logic [AW-1:0] TD_ADDR = '0,
   parameter int            PORT_ID = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic          inflight_i,
   input  logic [AW-1:0] desc_i,
   input  logic [QW-1:0] cq_i,
   input  logic          push_ready_i,
   output logic          push_valid_o,
   output logic [QW-1:0] push_qnum_o,
   output logic [AW-1:0] push_desc_o,
   output logic          mem_we_o,
   output logic [AW-1:0] mem_addr_o,
   output logic [31:0]   mem_wdata_o,
   output logic          drop_o,
   output logic          active_o
);
   localparam logic [31:0] MARKER = marker_word(IS_RX, PORT_ID[4:0]);

   td_state_e st_q, st_d;
   logic      go_release;
   logic      early_drop;

   generate
      if (IS_RX) begin : g_rx_discard
         assign go_release = 1'b0;
         assign early_drop = start_i && inflight_i;
      end else begin : g_tx_return
         assign go_release = inflight_i;
         assign early_drop = 1'b0;
      end
   endgenerate

   always_comb begin
      st_d = st_q;
      case (st_q)
         TD_IDLE:      if (start_i) st_d = go_release ? TD_RELEASE : TD_MARK_WR;
         TD_RELEASE:   if (push_ready_i) st_d = TD_MARK_WR;
         TD_MARK_WR:   st_d = TD_MARK_PUSH;
         TD_MARK_PUSH: if (push_ready_i) st_d = TD_IDLE;
         default:      st_d = TD_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= TD_IDLE;
      else        st_q <= st_d;
   end

   assign active_o     = (st_q != TD_IDLE);
   assign drop_o       = ((st_q == TD_RELEASE) && push_ready_i) || ((st_q == TD_IDLE) && early_drop);
   assign push_valid_o = (st_q == TD_RELEASE) || (st_q == TD_MARK_PUSH);
   assign push_qnum_o  = (st_q == TD_RELEASE) ? cq_i : TD_CQ;
   assign push_desc_o  = (st_q == TD_RELEASE) ? desc_i : TD_ADDR;
   assign mem_we_o     = (st_q == TD_MARK_WR);
   assign mem_addr_o   = TD_ADDR;
   assign mem_wdata_o  = MARKER;

   p_push_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (push_valid_o && !push_ready_i) |=> (push_valid_o && $stable(push_desc_o) && $stable(push_qnum_o)));

   p_mark_then_push_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_q == TD_MARK_PUSH) |-> $past(mem_we_o));

   p_release_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_o |-> !inflight_i);

   generate
      if (IS_RX) begin : g_rx_chk
         p_rx_marker_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
            push_valid_o |-> (push_desc_o == TD_ADDR));
      end
   endgenerate
endmodule

// File: rtl/dma_chan_teardown.sv
module dma_chan_teardown
   import dct_pkg::*;
#(
   parameter bit            IS_RX        = 1'b0,
   parameter int            PORT_ID      = 0,
   parameter int            AW           = 32,
   parameter int            QW           = 12,
   parameter int            CQW          = 12,
   parameter logic [QW-1:0] TX_CQ_NUM    = 12'd40,
   parameter logic [QW-1:0] TD_CQ_NUM    = 12'd1,
   parameter logic [AW-1:0] TD_DESC_ADDR = 32'h0000_1000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_wr_en,
   input  logic [31:0]   cfg_wr_data,
   output logic [31:0]   cfg_value,
   output logic          chan_accept,
   output logic          teardown_busy,
   input  logic          xfer_load,
   input  logic [AW-1:0] xfer_desc,
   input  logic          xfer_done,
   output logic          xfer_busy,
   output logic          qpush_valid,
   input  logic          qpush_ready,
   output logic [QW-1:0] qpush_qnum,
   output logic [AW-1:0] qpush_desc,
   output logic          dmem_we,
   output logic [AW-1:0] dmem_addr,
   output logic [31:0]   dmem_wdata
);
   generate
      if (CQW < 1 || CQW > 14) begin : g_bad_cqw
         $error("CQW must lie in 1..14");
      end
      if (CQW > QW) begin : g_bad_qw
         $error("CQW must not exceed QW");
      end
      if (PORT_ID < 0 || PORT_ID > 31) begin : g_bad_port
         $error("PORT_ID must fit five bits");
      end
      if (AW < 6) begin : g_bad_aw
         $error("AW too small for aligned descriptors");
      end
   endgenerate

   logic          td_start;
   logic          td_active;
   logic          drop;
   logic [AW-1:0] cur_desc;
   logic [QW-1:0] comp_q;
   logic          load_ok;
   logic          done_ok;

   dct_cfg_reg #(.IS_RX(IS_RX), .CQW(CQW)) u_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en_i    (cfg_wr_en),
      .wr_data_i  (cfg_wr_data),
      .lock_i     (td_active),
      .cfg_o      (cfg_value),
      .td_start_o (td_start)
   );

   generate
      if (IS_RX) begin : g_rx_cq
         always_comb begin
            comp_q = '0;
            comp_q[CQW-1:0] = cfg_value[CQW-1:0];
         end
      end else begin : g_tx_cq
         assign comp_q = TX_CQ_NUM;
      end
   endgenerate

   assign chan_accept = cfg_value[CFG_EN_BIT] && !cfg_value[CFG_TD_BIT];
   assign load_ok     = xfer_load && chan_accept && !td_active && !td_start;
   assign done_ok     = xfer_done && !td_active;

   dct_inflight #(.AW(AW)) u_inflight (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (load_ok),
      .addr_i (xfer_desc),
      .done_i (done_ok),
      .drop_i (drop),
      .busy_o (xfer_busy),
      .desc_o (cur_desc)
   );

   dct_td_seq #(
      .IS_RX   (IS_RX),
      .AW      (AW),
      .QW      (QW),
      .TD_CQ   (TD_CQ_NUM),
      .TD_ADDR (TD_DESC_ADDR),
      .PORT_ID (PORT_ID)
   ) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (td_start),
      .inflight_i   (xfer_busy),
      .desc_i       (cur_desc),
      .cq_i         (comp_q),
      .push_ready_i (qpush_ready),
      .push_valid_o (qpush_valid),
      .push_qnum_o  (qpush_qnum),
      .push_desc_o  (qpush_desc),
      .mem_we_o     (dmem_we),
      .mem_addr_o   (dmem_addr),
      .mem_wdata_o  (dmem_wdata),
      .drop_o       (drop),
      .active_o     (td_active)
   );

   assign teardown_busy = td_active;

   p_no_accept_in_td_r9: assert property (@(posedge clk) disable iff (!rst_n)
      teardown_busy |-> !chan_accept);

   p_busy_from_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      td_start |=> teardown_busy);
endmodule

// File: tb/dma_chan_teardown_bench.sv
module dma_chan_teardown_bench;
   localparam int CLK_P = 10;
   localparam logic [31:0] TDA = 32'h0000_1000;
   localparam logic [11:0] TDQ = 12'd1;
   localparam logic [11:0] TXQ = 12'd40;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_wr_en = 1'b0;
   logic [31:0] cfg_wr_data = '0;
   logic xfer_load = 1'b0;
   logic [31:0] xfer_desc = '0;
   logic xfer_done = 1'b0;
   logic qpush_ready = 1'b1;

   always #(CLK_P/2) clk = ~clk;

   logic [31:0] o_cfg [2];
   logic        o_acc [2];
   logic        o_tdb [2];
   logic        o_xb  [2];
   logic        o_pv  [2];
   logic [11:0] o_pq  [2];
   logic [31:0] o_pd  [2];
   logic        o_we  [2];
   logic [31:0] o_wa  [2];
   logic [31:0] o_wd  [2];

   dma_chan_teardown #(.IS_RX(1'b0), .PORT_ID(5)) u_dma_chan_teardown (
      .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
      .cfg_value(o_cfg[0]), .chan_accept(o_acc[0]), .teardown_busy(o_tdb[0]),
      .xfer_load(xfer_load), .xfer_desc(xfer_desc), .xfer_done(xfer_done), .xfer_busy(o_xb[0]),
      .qpush_valid(o_pv[0]), .qpush_ready(qpush_ready), .qpush_qnum(o_pq[0]), .qpush_desc(o_pd[0]),
      .dmem_we(o_we[0]), .dmem_addr(o_wa[0]), .dmem_wdata(o_wd[0]));

   dma_chan_teardown #(.IS_RX(1'b1), .PORT_ID(3)) u_dma_chan_teardown_rx (
      .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
      .cfg_value(o_cfg[1]), .chan_accept(o_acc[1]), .teardown_busy(o_tdb[1]),
      .xfer_load(xfer_load), .xfer_desc(xfer_desc), .xfer_done(xfer_done), .xfer_busy(o_xb[1]),
      .qpush_valid(o_pv[1]), .qpush_ready(qpush_ready), .qpush_qnum(o_pq[1]), .qpush_desc(o_pd[1]),
      .dmem_we(o_we[1]), .dmem_addr(o_wa[1]), .dmem_wdata(o_wd[1]));

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   // behavioural reference: 0 idle, 1 release, 2 marker write, 3 marker push
   int          m_st   [2];
   logic [31:0] m_cfg  [2];
   bit          m_busy [2];
   logic [31:0] m_desc [2];

   function automatic logic [31:0] keep(input int ch);
      return (ch == 1) ? 32'hC100_4FFF : 32'hC000_0000;
   endfunction

   function automatic logic [31:0] marker(input int ch);
      return (ch == 1) ? 32'h9801_0003 : 32'h9800_0005;
   endfunction

   always @(posedge clk) begin
      for (int ch = 0; ch < 2; ch++) begin
         if (!rst_n) begin
            m_st[ch] = 0; m_cfg[ch] = '0; m_busy[ch] = 1'b0; m_desc[ch] = '0;
         end else begin
            case (m_st[ch])
               0: begin
                  bit acc;
                  bit start;
                  acc = m_cfg[ch][31] && !m_cfg[ch][30];
                  start = cfg_wr_en && cfg_wr_data[31] && cfg_wr_data[30];
                  if (cfg_wr_en) m_cfg[ch] = cfg_wr_data & keep(ch);
                  if (start) begin
                     if (m_busy[ch] && ch == 0) m_st[ch] = 1;
                     else begin m_st[ch] = 2; m_busy[ch] = 1'b0; end
                  end else if (xfer_load && acc && !m_busy[ch]) begin
                     m_busy[ch] = 1'b1; m_desc[ch] = xfer_desc;
                  end else if (xfer_done) begin
                     m_busy[ch] = 1'b0;
                  end
               end
               1: if (qpush_ready) begin m_busy[ch] = 1'b0; m_st[ch] = 2; end
               2: m_st[ch] = 3;
               default: if (qpush_ready) m_st[ch] = 0;
            endcase
         end
      end
   end

   // per-cycle comparison plus handshake monitor
   int rel_cnt [2];
   int mark_cnt [2];
   int busy_cyc [2];
   logic [31:0] last_mark [2];

   initial begin
      for (int ch = 0; ch < 2; ch++) begin
         rel_cnt[ch] = 0; mark_cnt[ch] = 0; busy_cyc[ch] = 0; last_mark[ch] = '0;
      end
   end

   always begin
      @(negedge clk);
      #1;
      if (rst_n) begin
         for (int ch = 0; ch < 2; ch++) begin
            logic [11:0] cq;
            cq = (ch == 1) ? m_cfg[1][11:0] : TXQ;
            check("R2 cfg_value", 64'(o_cfg[ch]), 64'(m_cfg[ch]));
            check("R3 chan_accept", 64'(o_acc[ch]), 64'(m_cfg[ch][31] && !m_cfg[ch][30]));
            check("R9 teardown_busy", 64'(o_tdb[ch]), 64'(m_st[ch] != 0));
            check("R3 xfer_busy", 64'(o_xb[ch]), 64'(m_busy[ch]));
            check("R8 qpush_valid", 64'(o_pv[ch]), 64'(m_st[ch] == 1 || m_st[ch] == 3));
            if (m_st[ch] == 1) begin
               check("R4 release qnum", 64'(o_pq[ch]), 64'(cq));
               check("R4 release desc", 64'(o_pd[ch]), 64'(m_desc[ch]));
            end
            if (m_st[ch] == 3) begin
               check("R8 marker qnum", 64'(o_pq[ch]), 64'(TDQ));
               check("R8 marker desc", 64'(o_pd[ch]), 64'(TDA));
            end
            check("R7 dmem_we", 64'(o_we[ch]), 64'(m_st[ch] == 2));
            if (m_st[ch] == 2) begin
               check("R7 dmem_addr", 64'(o_wa[ch]), 64'(TDA));
               check("R7 dmem_wdata", 64'(o_wd[ch]), 64'(marker(ch)));
            end
            if (o_pv[ch] && qpush_ready) begin
               if (o_pd[ch] == TDA) mark_cnt[ch]++;
               else rel_cnt[ch]++;
            end
            if (o_we[ch]) last_mark[ch] = o_wd[ch];
            if (o_tdb[ch]) busy_cyc[ch]++;
         end
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [31:0] d);
      @(negedge clk); cfg_wr_en = 1'b1; cfg_wr_data = d;
      @(negedge clk); cfg_wr_en = 1'b0; cfg_wr_data = '0;
   endtask

   task automatic load(input logic [31:0] a);
      @(negedge clk); xfer_load = 1'b1; xfer_desc = a;
      @(negedge clk); xfer_load = 1'b0;
   endtask

   initial begin
      cyc(3);
      #2;
      for (int ch = 0; ch < 2; ch++) begin
         check("R1 reset cfg", 64'(o_cfg[ch]), 64'h0);
         check("R1 reset busy", 64'(o_tdb[ch] | o_xb[ch]), 64'h0);
         check("R1 reset push/write", 64'(o_pv[ch] | o_we[ch]), 64'h0);
      end
      @(negedge clk); rst_n = 1'b1;

      wr(32'h8110_40A5);
      #2;
      check("R2 tx masking", 64'(o_cfg[0]), 64'h8000_0000);
      check("R2 rx masking", 64'(o_cfg[1]), 64'h8100_40A5);

      load(32'h2000_0040);
      #2;
      check("R3 load captured", 64'({o_xb[0], o_xb[1]}), 64'h3);
      @(negedge clk); xfer_done = 1'b1;
      @(negedge clk); xfer_done = 1'b0;
      #2;
      check("R3 done clears", 64'({o_xb[0], o_xb[1]}), 64'h0);
      load(32'h2000_0080);

      // teardown while busy, push port stalled
      @(negedge clk); qpush_ready = 1'b0;
      wr(32'hC110_40A5);
      cyc(1);
      #2;
      check("R4 tx offers in-flight first", 64'({o_pv[0], o_pd[0]}), {31'd0, 1'b1, 32'h2000_0080});
      check("R4 marker not yet written", 64'(o_we[0]), 64'h0);
      check("R5 rx dropped in-flight", 64'(o_xb[1]), 64'h0);
      wr(32'h8000_0000);
      #2;
      check("R10 tx cfg frozen", 64'(o_cfg[0]), 64'hC000_0000);
      check("R10 rx cfg frozen", 64'(o_cfg[1]), 64'hC100_40A5);
      check("R8 push held under stall", 64'({o_pv[0], o_pv[1]}), 64'h3);
      @(negedge clk); qpush_ready = 1'b1;
      cyc(6);
      #2;
      check("R4 tx released once", 64'(rel_cnt[0]), 64'd1);
      check("R5 rx released nothing", 64'(rel_cnt[1]), 64'd0);
      check("R8 tx marker pushed", 64'(mark_cnt[0]), 64'd1);
      check("R8 rx marker pushed", 64'(mark_cnt[1]), 64'd1);
      check("R7 tx marker word", 64'(last_mark[0]), 64'h9800_0005);
      check("R7 rx marker word", 64'(last_mark[1]), 64'h9801_0003);
      check("R9 busy dropped", 64'({o_tdb[0], o_tdb[1]}), 64'h0);

      wr(32'h0000_0000);
      load(32'h2000_00C0);
      #2;
      check("R11 tx off", 64'({o_cfg[0], 31'd0, o_acc[0]}), 64'h0);
      check("R11 rx off", 64'({o_cfg[1], 31'd0, o_acc[1]}), 64'h0);
      check("R3 load ignored when disabled", 64'({o_xb[0], o_xb[1]}), 64'h0);

      // idle teardown
      wr(32'h8000_0007);
      busy_cyc[0] = 0; busy_cyc[1] = 0;
      wr(32'hC000_0007);
      cyc(5);
      #2;
      check("R6 tx idle: no release", 64'(rel_cnt[0]), 64'd1);
      check("R6 tx idle marker", 64'(mark_cnt[0]), 64'd2);
      check("R12 tx idle duration", 64'(busy_cyc[0]), 64'd2);
      check("R12 rx idle duration", 64'(busy_cyc[1]), 64'd2);

      // busy teardown with ready high
      wr(32'h0000_0000);
      wr(32'h8000_0007);
      load(32'h2000_0100);
      busy_cyc[0] = 0; busy_cyc[1] = 0;
      wr(32'hC000_0007);
      cyc(6);
      #2;
      check("R12 tx busy duration", 64'(busy_cyc[0]), 64'd3);
      check("R12 rx busy duration", 64'(busy_cyc[1]), 64'd2);
      check("R4 tx second release", 64'(rel_cnt[0]), 64'd2);
      check("R5 rx still no release", 64'(rel_cnt[1]), 64'd0);

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual hung expected finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule